// File: doc/BRIEF.md
# TDM Time-Slot Channel Mapper

This block sits between a frame-aligned serial PCM line and a set of up to 64 logical channels. A frame holds either 24 or 32 eight-bit time slots, sent most significant bit first, one line bit per clock cycle. A frame-sync input marks the first bit of slot 0. If no sync arrives, the block wraps to slot 0 by itself at the end of each frame.

Each direction has its own slot table with one entry per time slot. An entry holds an enable bit, a 6-bit channel number and an 8-bit mask that picks which bits of the slot belong to that channel. Several slots, adjacent or not, may carry the same channel number and so form one wide channel. A partial mask carves a narrow subchannel out of a single slot.

On receive, every selected bit comes out with a valid strobe and its channel number, in the order the bits arrived. On transmit, the block names the channel that owns the current bit. The channel answers with a data bit in the same cycle, and the block registers it onto the line. Table writes and the frame-length setting go into a shadow copy, which is loaded into the working copy only when a frame starts.

Top module: `tdm_slot_mapper`

## Requirements
- R1: After reset every table entry is disabled: `rx_valid` is 0 and `tx_line` is 1 until a table entry takes effect.
- R2: When the current bit's receive entry is enabled and its mask bit is 1, one cycle later `rx_valid`=1, `rx_chan` is the entry's channel and `rx_data` is the bit sampled on `rx_bit`. Mask bit 7 selects the first bit of the slot and mask bit 0 the last.
- R3: A receive bit whose entry is disabled, or whose mask bit is 0, is dropped: `rx_valid` is 0 in the following cycle.
- R4: When the current bit's transmit entry is enabled and its mask bit is 1, `tx_req`=1 and `tx_chan` is the entry's channel in that same cycle, and `tx_line` equals that cycle's `tx_data` one cycle later.
- R5: A transmit bit that is not selected gives `tx_req`=0 and `tx_line`=1 one cycle later.
- R6: With `frame_mode`=0 a frame is 24 slots (192 bits); with `frame_mode`=1 it is 32 slots (256 bits). After the last bit the position wraps to slot 0, bit 0 without a sync. A change of `frame_mode` applies from the next frame start.
- R7: `fsync`=1 makes the current bit slot 0, bit 0, whatever the running position.
- R8: A table write (`cfg_we`) is applied to the working table at the next frame start. A write made in the same cycle as a frame start waits for the following frame.
- R9: `cfg_dir`=0 writes the receive table and `cfg_dir`=1 writes the transmit table; a write to one table never changes the other.
- R10: Any set of slots, not necessarily adjacent, may carry the same channel number, and each one maps independently.
- R11: Channel numbers 0 to 63 are all carried unchanged on `rx_chan` and `tx_chan`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Marks the first bit of slot 0 |
| frame_mode | input | 1 | 0: 24-slot frame, 1: 32-slot frame |
| rx_bit | input | 1 | Received line bit |
| cfg_we | input | 1 | Table write strobe |
| cfg_dir | input | 1 | Table select: 0 receive, 1 transmit |
| cfg_slot | input | 5 | Slot index to write |
| cfg_en | input | 1 | Entry enable |
| cfg_chan | input | 6 | Entry channel number |
| cfg_mask | input | 8 | Entry bit mask, bit 7 = first bit of the slot |
| rx_valid | output | 1 | Receive bit strobe |
| rx_chan | output | 6 | Channel of the received bit |
| rx_data | output | 1 | Received bit value |
| tx_req | output | 1 | A channel owns the current transmit bit |
| tx_chan | output | 6 | Channel asked for the bit |
| tx_data | input | 1 | Bit returned by the channel, same cycle |
| tx_line | output | 1 | Transmitted line bit |

## Verification
On every cycle the assertions check these points:
- the transmit line follows the returned data when a channel is asked for the bit, and idles at 1 otherwise;
- a receive strobe always carries the bit sampled one cycle earlier;
- a sync restarts the bit position;
- the bit position never goes past the end of a 24-slot frame while the short layout is in force.

Some behaviour only the bench scenarios can show, because it needs a reference model that tracks the shadow and working tables across frames:
- that writes are deferred to a frame start;
- that mask bits select the right bits in the right order;
- that the two tables stay separate;
- that a channel spread over non-adjacent slots comes out correctly.

// File: rtl/tsm_pkg.sv
package tsm_pkg;
    localparam int CH_W = 6;
    localparam int SLOT_BITS = 8;

    typedef struct packed {
        logic                 en;
        logic [CH_W-1:0]      chan;
        logic [SLOT_BITS-1:0] mask;
    } slot_entry_t;
endpackage

// File: rtl/tsm_frame_counter.sv
module tsm_frame_counter #(
    parameter int SLOTS_LONG  = 32,
    parameter int SLOTS_SHORT = 24,
    parameter int BITS        = 8,
    localparam int POS_W  = $clog2(SLOTS_LONG * BITS),
    localparam int SLOT_W = $clog2(SLOTS_LONG),
    localparam int BIT_W  = $clog2(BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fsync,
    input  logic              frame_mode,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [BIT_W-1:0]  cur_bit,
    output logic              frame_start,
    output logic [POS_W-1:0]  pos_q_o,
    output logic              mode_q_o
);
    localparam logic [POS_W-1:0] LAST_LONG  = POS_W'(SLOTS_LONG * BITS - 1);
    localparam logic [POS_W-1:0] LAST_SHORT = POS_W'(SLOTS_SHORT * BITS - 1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
        logic             mode;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;
    logic [POS_W-1:0] pos_eff;
    logic             mode_eff;
    logic [POS_W-1:0] last_pos;

    always_comb begin
        pos_eff     = fsync ? '0 : cnt_q.pos;
        frame_start = (pos_eff == '0);
        mode_eff    = frame_start ? frame_mode : cnt_q.mode;
        last_pos    = mode_eff ? LAST_LONG : LAST_SHORT;
        cnt_d.mode  = mode_eff;
        cnt_d.pos   = (pos_eff == last_pos) ? '0 : pos_eff + POS_W'(1);
        cur_slot    = pos_eff[POS_W-1:BIT_W];
        cur_bit     = pos_eff[BIT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pos_q_o  = cnt_q.pos;
    assign mode_q_o = cnt_q.mode;
endmodule

// File: rtl/tsm_slot_table.sv
module tsm_slot_table
    import tsm_pkg::*;
#(
    parameter int SLOTS = 32,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  slot_entry_t       wr_entry,
    input  logic              commit,
    input  logic [SLOT_W-1:0] rd_slot,
    output slot_entry_t       rd_entry
);
    typedef struct packed {
        slot_entry_t [SLOTS-1:0] shadow;
        slot_entry_t [SLOTS-1:0] active;
    } tbl_state_t;

    tbl_state_t tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        // load the working copy first, so a write in this cycle waits a frame
        if (commit) tbl_d.active = tbl_q.shadow;
        if (wr_en)  tbl_d.shadow[wr_slot] = wr_entry;
        rd_entry = commit ? tbl_q.shadow[rd_slot] : tbl_q.active[rd_slot];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end
endmodule

// File: rtl/tdm_slot_mapper.sv
module tdm_slot_mapper
    import tsm_pkg::*;
#(
    parameter int SLOTS_LONG  = 32,
    parameter int SLOTS_SHORT = 24,
    localparam int SLOT_W = $clog2(SLOTS_LONG),
    localparam int BIT_W  = $clog2(SLOT_BITS),
    localparam int POS_W  = $clog2(SLOTS_LONG * SLOT_BITS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fsync,
    input  logic                 frame_mode,
    input  logic                 rx_bit,
    input  logic                 cfg_we,
    input  logic                 cfg_dir,
    input  logic [SLOT_W-1:0]    cfg_slot,
    input  logic                 cfg_en,
    input  logic [CH_W-1:0]      cfg_chan,
    input  logic [SLOT_BITS-1:0] cfg_mask,
    output logic                 rx_valid,
    output logic [CH_W-1:0]      rx_chan,
    output logic                 rx_data,
    output logic                 tx_req,
    output logic [CH_W-1:0]      tx_chan,
    input  logic                 tx_data,
    output logic                 tx_line
);
    localparam int DIR_RX = 0;
    localparam int DIR_TX = 1;

    logic [SLOT_W-1:0] cur_slot;
    logic [BIT_W-1:0]  cur_bit;
    logic [BIT_W-1:0]  mask_idx;
    logic              frame_start;
    logic [POS_W-1:0]  frame_pos_q;
    logic              frame_mode_q;
    slot_entry_t       wr_entry;
    slot_entry_t       ent [2];
    logic              sel [2];

    tsm_frame_counter #(
        .SLOTS_LONG (SLOTS_LONG),
        .SLOTS_SHORT(SLOTS_SHORT),
        .BITS       (SLOT_BITS)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .fsync      (fsync),
        .frame_mode (frame_mode),
        .cur_slot   (cur_slot),
        .cur_bit    (cur_bit),
        .frame_start(frame_start),
        .pos_q_o    (frame_pos_q),
        .mode_q_o   (frame_mode_q)
    );

    assign wr_entry = '{en: cfg_en, chan: cfg_chan, mask: cfg_mask};
    assign mask_idx = BIT_W'(SLOT_BITS - 1) - cur_bit;

    for (genvar g = 0; g < 2; g++) begin : g_dir
        tsm_slot_table #(.SLOTS(SLOTS_LONG)) u_tbl (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_we && (cfg_dir == 1'(g))),
            .wr_slot (cfg_slot),
            .wr_entry(wr_entry),
            .commit  (frame_start),
            .rd_slot (cur_slot),
            .rd_entry(ent[g])
        );
        assign sel[g] = ent[g].en && ent[g].mask[mask_idx];
    end

    typedef struct packed {
        logic            rx_valid;
        logic [CH_W-1:0] rx_chan;
        logic            rx_data;
        logic            tx_line;
    } out_state_t;

    out_state_t out_d, out_q;

    always_comb begin
        out_d.rx_valid = sel[DIR_RX];
        out_d.rx_chan  = sel[DIR_RX] ? ent[DIR_RX].chan : '0;
        out_d.rx_data  = sel[DIR_RX] ? rx_bit : 1'b0;
        out_d.tx_line  = sel[DIR_TX] ? tx_data : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{rx_valid: 1'b0, rx_chan: '0, rx_data: 1'b0, tx_line: 1'b1};
        else        out_q <= out_d;
    end

    assign rx_valid = out_q.rx_valid;
    assign rx_chan  = out_q.rx_chan;
    assign rx_data  = out_q.rx_data;
    assign tx_req   = sel[DIR_TX];
    assign tx_chan  = sel[DIR_TX] ? ent[DIR_TX].chan : '0;
    assign tx_line  = out_q.tx_line;
endmodule

module tsm_checker #(
    parameter int POS_W     = 8,
    parameter int SHORT_LEN = 192
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fsync,
    input logic             rx_bit,
    input logic             rx_valid,
    input logic             rx_data,
    input logic             tx_req,
    input logic             tx_data,
    input logic             tx_line,
    input logic [POS_W-1:0] frame_pos_q,
    input logic             frame_mode_q
);
    assert_tx_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |=> (tx_line == $past(tx_data)));

    assert_tx_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_req |=> tx_line);

    assert_rx_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (rx_valid |-> (rx_data == $past(rx_bit))));

    assert_sync_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> (frame_pos_q == POS_W'(1)));

    assert_short_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_mode_q |-> (int'(frame_pos_q) < SHORT_LEN));
endmodule

bind tdm_slot_mapper tsm_checker #(
    .POS_W    (POS_W),
    .SHORT_LEN(SLOTS_SHORT * tsm_pkg::SLOT_BITS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fsync       (fsync),
    .rx_bit      (rx_bit),
    .rx_valid    (rx_valid),
    .rx_data     (rx_data),
    .tx_req      (tx_req),
    .tx_data     (tx_data),
    .tx_line     (tx_line),
    .frame_pos_q (frame_pos_q),
    .frame_mode_q(frame_mode_q)
);

// File: tb/tdm_slot_mapper_tb.sv
module tdm_slot_mapper_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0, frame_mode = 1'b1, rx_bit = 1'b0;
    logic       cfg_we = 1'b0, cfg_dir = 1'b0, cfg_en = 1'b0;
    logic [4:0] cfg_slot = '0;
    logic [5:0] cfg_chan = '0;
    logic [7:0] cfg_mask = '0;
    logic       rx_valid, rx_data, tx_req, tx_line;
    logic       tx_data = 1'b0;
    logic [5:0] rx_chan, tx_chan;

    always #5 clk = ~clk;

    tdm_slot_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .frame_mode(frame_mode),
        .rx_bit(rx_bit), .cfg_we(cfg_we), .cfg_dir(cfg_dir), .cfg_slot(cfg_slot),
        .cfg_en(cfg_en), .cfg_chan(cfg_chan), .cfg_mask(cfg_mask),
        .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_data(rx_data),
        .tx_req(tx_req), .tx_chan(tx_chan), .tx_data(tx_data), .tx_line(tx_line)
    );

    int total = 0, bad = 0;
    string scen = "";

    // reference model: [dir][slot] = {en, chan, mask}
    logic [14:0] m_shd [2][32];
    logic [14:0] m_act [2][32];
    int          m_pos = 0;
    logic        m_mode = 1'b0;

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, scen, act, exp);
        end
    endtask

    function automatic logic entry_sel(logic [14:0] e, int bitn);
        return e[14] && e[7 - bitn];
    endfunction

    // one line bit; inputs are driven at the negedge on entry
    task automatic step(bit fs, bit we, bit dir, int slot, bit en, int ch, int mask);
        int  pe, last;
        bit  rs, ts, d_in, d_tx, wrap;
        logic [14:0] re, te;
        d_in = 1'($urandom);
        d_tx = 1'($urandom);
        fsync = fs; cfg_we = we; cfg_dir = dir; cfg_slot = 5'(slot);
        cfg_en = en; cfg_chan = 6'(ch); cfg_mask = 8'(mask);
        rx_bit = d_in; tx_data = d_tx;
        pe = fs ? 0 : m_pos;
        wrap = (pe == 0) && !fs;
        if (pe == 0) begin
            m_act = m_shd;
            m_mode = frame_mode;
        end
        re = m_act[0][pe / 8];
        te = m_act[1][pe / 8];
        rs = entry_sel(re, pe % 8);
        ts = entry_sel(te, pe % 8);
        #1;
        if (ts) begin
            check("R4 tx_req", int'(tx_req), 1);
            check("R4 tx_chan", int'(tx_chan), int'(te[13:8]));
        end else begin
            check("R5 tx_req", int'(tx_req), 0);
        end
        @(posedge clk);
        #1;
        if (rs) begin
            check(wrap ? "R6 rx_valid" : (fs ? "R7 rx_valid" : "R2 rx_valid"), int'(rx_valid), 1);
            check("R2 rx_chan", int'(rx_chan), int'(re[13:8]));
            check("R2 rx_data", int'(rx_data), int'(d_in));
        end else begin
            check(wrap ? "R6 rx_valid" : "R3 rx_valid", int'(rx_valid), 0);
        end
        check(ts ? "R4 tx_line" : "R5 tx_line", int'(tx_line), ts ? int'(d_tx) : 1);
        if (we) m_shd[dir][slot] = {en, 6'(ch), 8'(mask)};
        last = m_mode ? 255 : 191;
        m_pos = (pe == last) ? 0 : pe + 1;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wr(bit dir, int slot, bit en, int ch, int mask);
        step(0, 1, dir, slot, en, ch, mask);
    endtask

    initial begin
        #2000000;
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int d = 0; d < 2; d++)
            for (int s = 0; s < 32; s++) begin
                m_shd[d][s] = '0;
                m_act[d][s] = '0;
            end
        repeat (3) @(negedge clk);
        // R1: outputs idle straight after reset
        check("R1 rx_valid", int'(rx_valid), 0);
        check("R1 tx_line", int'(tx_line), 1);
        rst_n = 1'b1;
        @(negedge clk);
        m_mode = 1'b0;
        scen = "reset idle R1";
        idle(20);

        // R10 and R11: channel 63 over slots 3, 17, 30; R9: rx-only write;
        // R8: these writes are deferred until the next frame start
        scen = "superchannel R10 R11 R9 R8";
        wr(0, 3, 1, 63, 8'hFF);
        wr(0, 17, 1, 63, 8'hFF);
        wr(0, 30, 1, 63, 8'hFF);
        wr(0, 5, 1, 0, 8'hA5);
        wr(1, 3, 1, 5, 8'hA5);
        wr(1, 9, 1, 63, 8'h0F);
        wr(1, 10, 0, 12, 8'hFF);
        step(1, 0, 0, 0, 0, 0, 0);
        idle(300);

        // R6: short frames wrap without a sync; mode change waits for a boundary
        scen = "short frame R6";
        frame_mode = 1'b0;
        idle(600);

        // R7: sync in the middle of a frame restarts the position
        scen = "midframe sync R7";
        idle(37);
        step(1, 0, 0, 0, 0, 0, 0);
        idle(250);

        // R8: rewrite a live slot mid-frame, then write exactly at a sync
        scen = "deferred write R8";
        wr(0, 3, 1, 7, 8'h3C);
        idle(100);
        step(1, 1, 1, 9, 1, 33, 8'hF0);
        idle(400);

        // random mix of writes, syncs and mode changes
        scen = "random";
        frame_mode = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 999) == 0) frame_mode = ~frame_mode;
            if ($urandom_range(0, 7) == 0)
                step($urandom_range(0, 399) == 0, 1, 1'($urandom),
                     $urandom_range(0, 31), 1'($urandom_range(0, 3) != 0),
                     $urandom_range(0, 63), $urandom_range(0, 255));
            else
                step($urandom_range(0, 399) == 0, 0, 0, 0, 0, 0, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule